// File: doc/BRIEF.md
# Serial Lock-Register Write Engine

This block is the command front end of a serial flash-style memory. It watches a serial clock, an active-low chip select and a single serial data line. From these it recognises two commands: one that arms a write-enable latch, and one that writes a small volatile lock register belonging to one sector of the memory. Every sector has a 2-bit lock register. Bit 0 is a write-lock flag. Bit 1 is a lock-down flag, which freezes that register until reset.

The serial inputs pass through a synchroniser and are then sampled on the system clock. Each command is acted on only when chip select rises, and only if the frame was exactly the right length. A lock write also needs the latch to have been armed by an earlier command, and the external busy flag, which shows that a program, erase or write cycle is running, must be low. The full lock array and the latch are available as registered outputs. Other logic, such as the program and erase sequencer, uses them to decide which sectors may be modified.

Top module: `lkw_engine`

## Requirements
- R1: A lock-register write takes effect only when the write-enable latch was already set before the frame ended. Without the latch the frame has no effect on any lock register.
- R2: The data line is sampled on rising edges of the serial clock while chip select is low. A lock-write frame is the opcode 0xE5, then a 24-bit address, then one data byte, each sent most significant bit first, for 40 bits in all.
- R3: The sector written is address bits [20:16], giving 32 sectors of 64 KB each. All other address bits are ignored, so any address inside a sector selects that sector.
- R4: Chip select must rise directly after the 40th bit of a lock-write frame. A frame of 39 or 41 bits changes neither the lock registers nor the latch.
- R5: The selected sector's register takes data bits [1:0]: bit 0 is write-lock and bit 1 is lock-down. Data bits [7:2] are ignored. The new value appears on `lock_bits` within a few system clocks of chip select rising, and no busy period follows.
- R6: An accepted lock-write frame clears the write-enable latch.
- R7: If `wip_busy` is high when chip select rises at the end of a lock-write frame, the frame is rejected. The lock registers and the latch keep their values.
- R8: A frame with any opcode other than 0x06 or 0xE5 is ignored completely, whatever its length.
- R9: Once a sector's lock-down bit is set, later accepted writes to that sector leave its register unchanged. The frame still clears the latch.
- R10: A frame with opcode 0x06 sets the latch only when chip select rises directly after its 8th bit. Frames of 7 or 9 bits leave the latch clear.
- R11: Synchronous reset (`rst` high) clears every lock register and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, data sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select, frames a command |
| spi_mosi | input | 1 | Serial data input |
| wip_busy | input | 1 | High while a program, erase or write cycle runs |
| lock_bits | output | 64 | Lock array, sector n at bits [2n+1:2n] |
| wel | output | 1 | Write-enable latch |

## Verification
A bit counter or shift register that is off by one position shows up at the ports as soon as the next frame ends: either an exact-length frame is rejected, or `lock_bits` lands in the wrong sector or holds shifted data. The bench therefore checks frames one bit short and one bit long as well as exact ones. It also writes sectors at both ends of the array and uses addresses with high bits set. A latch that sets or clears wrongly shows on `wel` a few clocks after chip select rises. It also shows on the following lock-write frame, which is then accepted or rejected against expectation.

// File: rtl/lkw_pkg.sv
package lkw_pkg;
  localparam logic [7:0] OP_ARM  = 8'h06;
  localparam logic [7:0] OP_LOCK = 8'hE5;
  localparam int unsigned OP_BITS   = 8;
  localparam int unsigned DATA_BITS = 8;
endpackage

// File: rtl/lkw_sync.sv
module lkw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= {W{1'b1}};
          else if (s == 0) pipe[s] <= d;
          else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lkw_shifter.sv
module lkw_shifter #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SR_W  = 32,
  parameter int unsigned OP_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             end_pulse,
  output logic [CNT_W-1:0] end_cnt,
  output logic [OP_W-1:0]  opcode,
  output logic [SR_W-1:0]  sr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(OP_W - 1);

  logic             sclk_q, cs_q;
  logic [CNT_W-1:0] cnt;
  logic             bit_tick;

  assign bit_tick = sclk & ~sclk_q & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      cnt       <= '0;
      sr        <= '0;
      opcode    <= '0;
      end_pulse <= 1'b0;
      end_cnt   <= '0;
    end else begin
      sclk_q    <= sclk;
      cs_q      <= cs_n;
      end_pulse <= cs_n & ~cs_q;
      end_cnt   <= cnt;
      if (cs_n) begin
        cnt <= '0;
      end else if (bit_tick) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        sr <= {sr[SR_W-2:0], mosi};
        if (cnt == OP_LAST) opcode <= {sr[OP_W-2:0], mosi};
      end
    end
  end
endmodule

// File: rtl/lkw_decoder.sv
module lkw_decoder
  import lkw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned SECT_LSB = 16,
  parameter int unsigned SECT_W   = 5,
  parameter int unsigned LK_W     = 2,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        end_pulse,
  input  logic [CNT_W-1:0]            end_cnt,
  input  logic [7:0]                  opcode,
  input  logic [ADDR_W+DATA_BITS-1:0] sr,
  input  logic                        busy,
  output logic                        lk_we,
  output logic [SECT_W-1:0]           lk_sel,
  output logic [LK_W-1:0]             lk_data,
  output logic                        wel,
  output logic                        wen_ok
);
  localparam logic [CNT_W-1:0] ARM_LEN  = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] LOCK_LEN = CNT_W'(OP_BITS + ADDR_W + DATA_BITS);

  logic lock_ok;

  always_comb begin
    wen_ok  = end_pulse && (end_cnt == ARM_LEN) && (opcode == OP_ARM);
    lock_ok = end_pulse && (end_cnt == LOCK_LEN) && (opcode == OP_LOCK)
              && wel && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel     <= 1'b0;
      lk_we   <= 1'b0;
      lk_sel  <= '0;
      lk_data <= '0;
    end else begin
      lk_we <= lock_ok;
      if (lock_ok) begin
        lk_sel  <= sr[DATA_BITS+SECT_LSB +: SECT_W];
        lk_data <= sr[LK_W-1:0];
        wel     <= 1'b0;
      end else if (wen_ok) begin
        wel <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lkw_lockbank.sv
module lkw_lockbank #(
  parameter int unsigned NSECT  = 32,
  parameter int unsigned LK_W   = 2,
  parameter int unsigned SECT_W = 5,
  parameter int unsigned LD_BIT = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [SECT_W-1:0]      sel,
  input  logic [LK_W-1:0]        data,
  output logic [NSECT*LK_W-1:0]  flat
);
  generate
    for (genvar i = 0; i < NSECT; i++) begin : g_sect
      logic [LK_W-1:0] reg_q;
      always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else if (we && (sel == SECT_W'(i)) && !reg_q[LD_BIT]) reg_q <= data;
      end
      assign flat[i*LK_W +: LK_W] = reg_q;
    end
  endgenerate
endmodule

// File: rtl/lkw_engine.sv
module lkw_engine
  import lkw_pkg::*;
#(
  parameter int unsigned NSECT       = 32,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned SECT_LSB    = 16,
  parameter int unsigned LK_W        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  input  logic                  wip_busy,
  output logic [NSECT*LK_W-1:0] lock_bits,
  output logic                  wel
);
  localparam int unsigned SECT_W     = $clog2(NSECT);
  localparam int unsigned FRAME_BITS = OP_BITS + ADDR_W + DATA_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int unsigned SR_W       = ADDR_W + DATA_BITS;

  logic [2:0]        sync_q;
  logic              end_pulse;
  logic [CNT_W-1:0]  end_cnt;
  logic [7:0]        opcode;
  logic [SR_W-1:0]   sr;
  logic              lk_we;
  logic [SECT_W-1:0] lk_sel;
  logic [LK_W-1:0]   lk_data;
  logic              wen_ok;

  lkw_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q(sync_q)
  );

  lkw_shifter #(.CNT_W(CNT_W), .SR_W(SR_W), .OP_W(OP_BITS)) shift_i (
    .clk(clk), .rst(rst),
    .sclk(sync_q[2]), .cs_n(sync_q[1]), .mosi(sync_q[0]),
    .end_pulse(end_pulse), .end_cnt(end_cnt), .opcode(opcode), .sr(sr)
  );

  lkw_decoder #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W),
    .LK_W(LK_W), .CNT_W(CNT_W)
  ) dec_i (
    .clk(clk), .rst(rst),
    .end_pulse(end_pulse), .end_cnt(end_cnt), .opcode(opcode), .sr(sr),
    .busy(wip_busy),
    .lk_we(lk_we), .lk_sel(lk_sel), .lk_data(lk_data),
    .wel(wel), .wen_ok(wen_ok)
  );

  lkw_lockbank #(.NSECT(NSECT), .LK_W(LK_W), .SECT_W(SECT_W), .LD_BIT(1)) bank_i (
    .clk(clk), .rst(rst),
    .we(lk_we), .sel(lk_sel), .data(lk_data),
    .flat(lock_bits)
  );
endmodule

// File: rtl/lkw_checker.sv
module lkw_checker #(
  parameter int unsigned NSECT = 32,
  parameter int unsigned LK_W  = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wip_busy,
  input logic                  wel,
  input logic [NSECT*LK_W-1:0] lock_bits,
  input logic                  lk_we,
  input logic                  wen_ok
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!wel && lock_bits == '0)); // R11

  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    lk_we |-> $past(wel)); // R1

  AST_WRITE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
    lk_we |-> !wel); // R6

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    lk_we |-> !$past(wip_busy)); // R7

  AST_LOCKS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_we |=> $stable(lock_bits)); // R4

  AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(wen_ok)); // R10

  generate
    for (genvar i = 0; i < NSECT; i++) begin : g_ld
      AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_bits[i*LK_W+1] |=> $stable(lock_bits[i*LK_W +: LK_W])); // R9
    end
  endgenerate
endmodule

bind lkw_engine lkw_checker #(.NSECT(NSECT), .LK_W(LK_W)) chk_i (
  .clk(clk), .rst(rst), .wip_busy(wip_busy), .wel(wel),
  .lock_bits(lock_bits), .lk_we(lk_we), .wen_ok(wen_ok)
);

// File: tb/lkw_engine_tb.sv
module lkw_engine_tb_top;
  localparam int CLK_NS = 10;
  localparam int NSECT  = 32;
  localparam int HALF   = 4;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  data;
    logic [5:0]  nbits;
    logic        busy;
    logic        exp_wel;
    logic [4:0]  sec;
    logic [1:0]  exp_lk;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TABLE [NV] = '{
    '{4'd1,  8'hE5, 24'h030000, 8'h01, 6'd40, 1'b0, 1'b0, 5'd3,  2'b00}, // R1 no latch
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd7,  1'b0, 1'b0, 5'd3,  2'b00}, // R10 short
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd9,  1'b0, 1'b0, 5'd3,  2'b00}, // R10 long
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd8,  1'b0, 1'b1, 5'd3,  2'b00}, // R10 exact
    '{4'd5,  8'hE5, 24'h03ABCD, 8'hFD, 6'd40, 1'b0, 1'b0, 5'd3,  2'b01}, // R2 R5 R6
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd8,  1'b0, 1'b1, 5'd5,  2'b00}, // R10
    '{4'd4,  8'hE5, 24'h050000, 8'h03, 6'd39, 1'b0, 1'b1, 5'd5,  2'b00}, // R4 short
    '{4'd4,  8'hE5, 24'h050000, 8'h03, 6'd41, 1'b0, 1'b1, 5'd5,  2'b00}, // R4 long
    '{4'd7,  8'hE5, 24'h050000, 8'h03, 6'd40, 1'b1, 1'b1, 5'd5,  2'b00}, // R7 busy
    '{4'd8,  8'h20, 24'h050000, 8'h03, 6'd40, 1'b0, 1'b1, 5'd5,  2'b00}, // R8 other op
    '{4'd3,  8'hE5, 24'h1F0000, 8'h02, 6'd40, 1'b0, 1'b0, 5'd31, 2'b10}, // R3 top sector
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd8,  1'b0, 1'b1, 5'd31, 2'b10}, // R10
    '{4'd9,  8'hE5, 24'h1F1234, 8'h01, 6'd40, 1'b0, 1'b0, 5'd31, 2'b10}, // R9 lock-down
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd8,  1'b0, 1'b1, 5'd0,  2'b00}, // R10
    '{4'd5,  8'hE5, 24'h000000, 8'h03, 6'd40, 1'b0, 1'b0, 5'd0,  2'b11}, // R5 sector 0
    '{4'd10, 8'h06, 24'h0,      8'h0,  6'd8,  1'b0, 1'b1, 5'd2,  2'b00}, // R10
    '{4'd3,  8'hE5, 24'hE2FFFF, 8'h01, 6'd40, 1'b0, 1'b0, 5'd2,  2'b01}  // R3 high addr bits
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, wip_busy = 1'b0;
  logic [NSECT*2-1:0] lock_bits;
  logic wel;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  lkw_engine dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .wip_busy(wip_busy), .lock_bits(lock_bits), .wel(wel)
  );

  task automatic check(input int req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] bits, input int n, input logic busy);
    @(negedge clk);
    wip_busy = busy;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 47; i > 47 - n; i--) begin
      spi_mosi = bits[i];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
    wip_busy = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired (all R): actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NSECT*2-1:0] exp_all;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(11, "reset latch", 64'(wel), 64'd0);        // R11
    check(11, "reset locks", 64'(lock_bits), 64'd0);  // R11

    for (int v = 0; v < NV; v++) begin
      send({TABLE[v].op, TABLE[v].addr, TABLE[v].data, 8'h00},
           int'(TABLE[v].nbits), TABLE[v].busy);
      check(int'(TABLE[v].req), $sformatf("vec %0d latch", v), 64'(wel),
            64'(TABLE[v].exp_wel));
      check(int'(TABLE[v].req), $sformatf("vec %0d sector %0d", v, TABLE[v].sec),
            64'(lock_bits[TABLE[v].sec*2 +: 2]), 64'(TABLE[v].exp_lk));
    end

    // R3 R5: whole array, only the written sectors are set
    exp_all = '0;
    exp_all[0*2 +: 2]  = 2'b11;
    exp_all[2*2 +: 2]  = 2'b01;
    exp_all[3*2 +: 2]  = 2'b01;
    exp_all[31*2 +: 2] = 2'b10;
    check(3, "full array", 64'(lock_bits), 64'(exp_all));

    // R11: reset with state present clears all
    send({8'h06, 40'h0}, 8, 1'b0);
    check(10, "arm before reset", 64'(wel), 64'd1);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(11, "reset clears latch", 64'(wel), 64'd0);
    check(11, "reset clears locks", 64'(lock_bits), 64'd0);

    // R9 after reset, lock-down no longer blocks sector 31
    send({8'h06, 40'h0}, 8, 1'b0);
    send({8'hE5, 24'h1F0000, 8'h01, 8'h00}, 40, 1'b0);
    check(9, "sector 31 writable after reset", 64'(lock_bits[62 +: 2]), 64'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule